// File: doc/BRIEF.md
# Line-Locked Pixel Clock Loop

This block derives a pixel-rate enable from a fast reference clock and keeps it locked to the horizontal sync of the incoming video. The pixel period is held as an 8.8 fixed-point count of reference cycles. A fractional accumulator fires one pixel strobe each time a full period has built up. Each active sync edge restarts the pixel phase. The pixels counted since the previous edge are compared with the programmed line length of 12 × (units + 1) pixels, and that signed difference is the phase error of the line.

The period is corrected once per line by a proportional-plus-integral rule. Both gains are right-shift amounts, selected from an acquisition pair or a tracking pair. A lock detector switches to the tracking pair after enough consecutive lines with a small error. It falls back to the acquisition pair on the first line whose error is large. Software loads a starting period through a load strobe, so a change of line rate converges quickly. A free-run input freezes the loop at its current period.

Top module: `line_lock_pll`

## Requirements
- R1: At most one pixel strobe is issued per reference cycle. The fractional accumulator adds 1.0 (256 in 8.8) each cycle, and it fires and subtracts the period whenever the sum reaches the period.
- R2: Reset sets the period to the parameter RST_PER (default 0x0800) with lock low. A one-cycle `init_load_i` sets the period and the integrator to `init_period_i` × 256 on the next cycle, clears lock, and ignores the next sync edge for measurement.
- R3: On each measured line the error is 12 × (`line_units_i` + 1) minus the pixel strobes counted since the previous sync edge.
- R4: `lock_o` rises only on a sync edge, and only at the 4th consecutive measured line whose error magnitude is below 2.
- R5: One measured line with an error magnitude of 2 or more clears `lock_o` at that sync edge. Apart from sync edges and loads, `lock_o` never changes.
- R6: The integrator moves by (error × 256) >>> (8 − Ki) and the period is the integrator minus (error × 256) >>> (9 − Kp). While locked, Kp/Ki come from `trk_kp_i`/`trk_ki_i`; otherwise they come from `acq_kp_i`/`acq_ki_i`.
- R7: While `free_run_i` is high, the period and the lock flag hold their values.
- R8: `hs_rise_i` = 1 takes the rising sync edge as the line start, and 0 takes the falling edge.
- R9: The integrator and the period saturate within 0x0200 (2.0 cycles) to 0xFFFF. A load of a value below 2 gives 0x0200.
- R10: In the cycle after a sync edge no pixel strobe is issued, and the accumulator and count restart from zero.
- R11: After a step in line rate the lock flag drops. It returns, with each line holding within 2 of 12 × (`line_units_i` + 1) strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, asynchronous to nothing but sampled through a synchronizer |
| hs_rise_i | input | 1 | 1: rising edge starts a line, 0: falling edge |
| line_units_i | input | 6 | Line length in units of 12 pixels, minus one |
| init_period_i | input | 8 | Starting period in whole reference cycles |
| init_load_i | input | 1 | One-cycle strobe that loads the starting period |
| acq_kp_i | input | 3 | Proportional gain while acquiring |
| acq_ki_i | input | 3 | Integral gain while acquiring |
| trk_kp_i | input | 3 | Proportional gain while locked |
| trk_ki_i | input | 3 | Integral gain while locked |
| free_run_i | input | 1 | Freeze period and lock state |
| pix_en_o | output | 1 | Pixel strobe, one reference cycle wide |
| period_o | output | 16 | Current period, 8.8 reference cycles |
| lock_o | output | 1 | Tracking gains in use |

## Verification
The assertions take for granted that sync pulses last longer than the two synchronizer stages. They also assume the gain, line-length and starting-period inputs are steady around a load strobe. Both assumptions leave the edge detector's pulses and the load path well defined. The stimulus drives every input on the falling clock edge, holds each sync pulse for eight cycles and changes register inputs only between lines. It exercises the lock transitions with a mid-line extra pulse and a step in line length, and it flips polarity together with the sync level.

// File: rtl/line_lock_pkg.sv
package line_lock_pkg;
  localparam int GAIN_W = 3;

  typedef struct packed {
    logic [GAIN_W-1:0] kp;
    logic [GAIN_W-1:0] ki;
  } gain_pair_t;
endpackage

// File: rtl/lk_sync_edge.sv
module lk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic rise_i,
  output logic evt_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], sig_i};
  end

  logic cur, prv;
  assign cur   = chain_q[STAGES-1];
  assign prv   = chain_q[STAGES];
  assign evt_o = rise_i ? (cur & ~prv) : (~cur & prv);
endmodule

// File: rtl/lk_pix_nco.sv
module lk_pix_nco #(
  parameter int PER_W  = 16,
  parameter int FRAC_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_evt_i,
  input  logic [PER_W-1:0] period_i,
  output logic             pix_en_o,
  output logic [CNT_W-1:0] pix_cnt_o
);
  localparam logic [PER_W:0] ONE     = (PER_W+1)'(1) << FRAC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PER_W-1:0] acc_q;
  logic [PER_W:0]   sum, rem;
  logic             hit;

  assign sum = {1'b0, acc_q} + ONE;
  assign hit = sum >= {1'b0, period_i};
  assign rem = sum - {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      pix_en_o  <= 1'b0;
      pix_cnt_o <= '0;
    end else if (line_evt_i) begin
      acc_q     <= '0;
      pix_en_o  <= 1'b0;
      pix_cnt_o <= '0;
    end else begin
      pix_en_o <= hit;
      acc_q    <= hit ? rem[PER_W-1:0] : sum[PER_W-1:0];
      if (hit && pix_cnt_o != CNT_MAX) pix_cnt_o <= pix_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/lk_loop_ctrl.sv
module lk_loop_ctrl
  import line_lock_pkg::*;
#(
  parameter int          PER_W      = 16,
  parameter int          FRAC_W     = 8,
  parameter int          CNT_W      = 12,
  parameter int          LD_W       = 6,
  parameter int          PIX_UNIT   = 12,
  parameter int          ERR_THR    = 2,
  parameter int          LOCK_LINES = 4,
  parameter int          P_BASE     = 9,
  parameter int          I_BASE     = 8,
  parameter logic [15:0] RST_PER    = 16'h0800
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    line_evt_i,
  input  logic [CNT_W-1:0]        pix_cnt_i,
  input  logic [LD_W-1:0]         line_units_i,
  input  logic [PER_W-FRAC_W-1:0] init_period_i,
  input  logic                    init_load_i,
  input  gain_pair_t              acq_i,
  input  gain_pair_t              trk_i,
  input  logic                    free_run_i,
  output logic [PER_W-1:0]        period_o,
  output logic                    lock_o
);
  localparam int ERR_W = CNT_W + 2;
  localparam int SC_W  = ERR_W + FRAC_W;
  localparam int WIDE  = SC_W + 2;
  localparam int LC_W  = $clog2(LOCK_LINES + 1);
  localparam int SH_W  = 4;
  localparam logic signed [WIDE-1:0] PMIN = WIDE'(2 << FRAC_W);
  localparam logic signed [WIDE-1:0] PMAX = WIDE'((1 << PER_W) - 1);
  localparam logic [LC_W-1:0] LOCK_N = LC_W'(LOCK_LINES);

  function automatic logic [PER_W-1:0] sat_per(input logic signed [WIDE-1:0] v);
    if (v < PMIN)      return PER_W'(PMIN);
    else if (v > PMAX) return PER_W'(PMAX);
    else               return v[PER_W-1:0];
  endfunction

  logic [PER_W-1:0] dint_q;
  logic [LC_W-1:0]  good_q;
  logic             armed_q;

  // expected pixels per line
  logic [CNT_W-1:0] n_exp;
  assign n_exp = CNT_W'(PIX_UNIT) * (CNT_W'(line_units_i) + 1'b1);

  logic signed [ERR_W-1:0] err, err_abs;
  assign err     = $signed({2'b00, n_exp}) - $signed({2'b00, pix_cnt_i});
  assign err_abs = err[ERR_W-1] ? -err : err;

  logic line_ok;
  assign line_ok = err_abs < ERR_W'(ERR_THR);

  gain_pair_t sel;
  assign sel = lock_o ? trk_i : acq_i;

  logic [SH_W-1:0] p_sh, i_sh;
  assign p_sh = SH_W'(P_BASE) - SH_W'(sel.kp);
  assign i_sh = SH_W'(I_BASE) - SH_W'(sel.ki);

  logic signed [SC_W-1:0] err_sc, p_term, i_step;
  assign err_sc = SC_W'(err) <<< FRAC_W;
  assign p_term = err_sc >>> p_sh;
  assign i_step = err_sc >>> i_sh;

  logic signed [WIDE-1:0] dint_wide, per_wide;
  logic [PER_W-1:0]       dint_nxt, per_nxt;
  assign dint_wide = $signed({{(WIDE-PER_W){1'b0}}, dint_q}) - WIDE'(i_step);
  assign dint_nxt  = sat_per(dint_wide);
  assign per_wide  = $signed({{(WIDE-PER_W){1'b0}}, dint_nxt}) - WIDE'(p_term);
  assign per_nxt   = sat_per(per_wide);

  logic [PER_W-1:0] load_val;
  assign load_val = sat_per($signed({{(WIDE-PER_W+FRAC_W){1'b0}}, init_period_i}) <<< FRAC_W);

  logic [LC_W-1:0] good_inc;
  assign good_inc = (good_q == LOCK_N) ? good_q : good_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dint_q   <= RST_PER;
      period_o <= RST_PER;
      good_q   <= '0;
      lock_o   <= 1'b0;
      armed_q  <= 1'b0;
    end else if (init_load_i) begin
      dint_q   <= load_val;
      period_o <= load_val;
      good_q   <= '0;
      lock_o   <= 1'b0;
      armed_q  <= 1'b0;
    end else if (line_evt_i) begin
      if (!armed_q) begin
        armed_q <= 1'b1;
      end else if (!free_run_i) begin
        dint_q   <= dint_nxt;
        period_o <= per_nxt;
        if (line_ok) begin
          good_q <= good_inc;
          lock_o <= good_inc == LOCK_N;
        end else begin
          good_q <= '0;
          lock_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/line_lock_pll.sv
module line_lock_pll
  import line_lock_pkg::*;
#(
  parameter int          PER_W       = 16,
  parameter int          FRAC_W      = 8,
  parameter int          CNT_W       = 12,
  parameter int          LD_W        = 6,
  parameter int          SYNC_STAGES = 2,
  parameter int          ERR_THR     = 2,
  parameter int          LOCK_LINES  = 4,
  parameter logic [15:0] RST_PER     = 16'h0800
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hsync_i,
  input  logic                    hs_rise_i,
  input  logic [LD_W-1:0]         line_units_i,
  input  logic [PER_W-FRAC_W-1:0] init_period_i,
  input  logic                    init_load_i,
  input  logic [GAIN_W-1:0]       acq_kp_i,
  input  logic [GAIN_W-1:0]       acq_ki_i,
  input  logic [GAIN_W-1:0]       trk_kp_i,
  input  logic [GAIN_W-1:0]       trk_ki_i,
  input  logic                    free_run_i,
  output logic                    pix_en_o,
  output logic [PER_W-1:0]        period_o,
  output logic                    lock_o
);
  logic             line_evt;
  logic [CNT_W-1:0] pix_cnt;
  gain_pair_t       acq, trk;

  assign acq = '{kp: acq_kp_i, ki: acq_ki_i};
  assign trk = '{kp: trk_kp_i, ki: trk_ki_i};

  lk_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (hsync_i),
    .rise_i (hs_rise_i),
    .evt_o  (line_evt)
  );

  lk_pix_nco #(.PER_W(PER_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_nco (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_evt_i (line_evt),
    .period_i   (period_o),
    .pix_en_o   (pix_en_o),
    .pix_cnt_o  (pix_cnt)
  );

  lk_loop_ctrl #(
    .PER_W(PER_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .LD_W(LD_W),
    .ERR_THR(ERR_THR), .LOCK_LINES(LOCK_LINES), .RST_PER(RST_PER)
  ) u_loop (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .line_evt_i    (line_evt),
    .pix_cnt_i     (pix_cnt),
    .line_units_i  (line_units_i),
    .init_period_i (init_period_i),
    .init_load_i   (init_load_i),
    .acq_i         (acq),
    .trk_i         (trk),
    .free_run_i    (free_run_i),
    .period_o      (period_o),
    .lock_o        (lock_o)
  );
endmodule

// File: rtl/line_lock_pll_chk.sv
module line_lock_pll_chk #(
  parameter int PER_W  = 16,
  parameter int FRAC_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    line_evt_i,
  input logic                    pix_en_o,
  input logic [PER_W-1:0]        period_o,
  input logic                    lock_o,
  input logic                    free_run_i,
  input logic                    init_load_i,
  input logic [PER_W-FRAC_W-1:0] init_period_i
);
  localparam logic [PER_W-1:0] PMIN = PER_W'(2 << FRAC_W);

  // R10
  pix_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_evt_i |=> !pix_en_o);

  // R9
  per_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o >= PMIN);

  // R7
  free_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_run_i && !init_load_i |=> $stable(period_o) && $stable(lock_o));

  // R2
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_load_i |=> !lock_o &&
      (period_o == (($past(init_period_i) < 2) ? PMIN : {$past(init_period_i), {FRAC_W{1'b0}}})));

  // R4
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(line_evt_i) && !$past(free_run_i));

  // R5
  lock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_evt_i && !init_load_i |=> $stable(lock_o));
endmodule

bind line_lock_pll line_lock_pll_chk #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .line_evt_i    (line_evt),
  .pix_en_o      (pix_en_o),
  .period_o      (period_o),
  .lock_o        (lock_o),
  .free_run_i    (free_run_i),
  .init_load_i   (init_load_i),
  .init_period_i (init_period_i)
);

// File: tb/sim_line_lock_pll.sv
`timescale 1ns/1ps
module sim_line_lock_pll;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0;
  logic       hs_rise = 1'b1;
  logic [5:0] ld = 6'd7;
  logic [7:0] init_p = 8'd7;
  logic       load = 1'b0;
  logic [2:0] akp = 3'd2, aki = 3'd3, tkp = 3'd0, tki = 3'd1;
  logic       free_run = 1'b0;
  logic       pix_en, lock;
  logic [15:0] period;

  always #4 clk = ~clk;

  line_lock_pll u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .hs_rise_i(hs_rise),
    .line_units_i(ld), .init_period_i(init_p), .init_load_i(load),
    .acq_kp_i(akp), .acq_ki_i(aki), .trk_kp_i(tkp), .trk_ki_i(tki),
    .free_run_i(free_run), .pix_en_o(pix_en), .period_o(period), .lock_o(lock)
  );

  int n_vec = 0, n_err = 0, cyc = 0;
  bit act_hi = 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int ms1 = 0, ms2 = 0, ms3 = 0, macc = 0, mcnt = 0, mpix = 0;
  int mdint = 2048, mper = 2048, mgood = 0, mlock = 0, marm = 0;

  function automatic int clampi(input int v);
    if (v < 512) return 512;
    if (v > 65535) return 65535;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; ms3 = 0; macc = 0; mcnt = 0; mpix = 0;
      mdint = 2048; mper = 2048; mgood = 0; mlock = 0; marm = 0;
    end else begin : mstep
      int s, e, d, p, a, b, nacc, ncnt, npix, ndint, nper, ngood, nlock, narm;
      bit ev;
      ev = hs_rise ? (ms2 == 1 && ms3 == 0) : (ms2 == 0 && ms3 == 1);
      if (ev) begin nacc = 0; npix = 0; ncnt = 0; end
      else begin
        s = macc + 256;
        if (s >= mper) begin nacc = s - mper; npix = 1; ncnt = (mcnt < 4095) ? mcnt + 1 : mcnt; end
        else begin nacc = s; npix = 0; ncnt = mcnt; end
      end
      ndint = mdint; nper = mper; ngood = mgood; nlock = mlock; narm = marm;
      if (load) begin
        ndint = (init_p < 2) ? 512 : int'(init_p) * 256;
        nper = ndint; ngood = 0; nlock = 0; narm = 0;
      end else if (ev) begin
        if (marm == 0) narm = 1;
        else if (!free_run) begin
          e = 12 * (int'(ld) + 1) - mcnt;
          a = mlock ? int'(tkp) : int'(akp);
          b = mlock ? int'(tki) : int'(aki);
          d = clampi(mdint - ((e * 256) >>> (8 - b)));
          p = clampi(d - ((e * 256) >>> (9 - a)));
          ndint = d; nper = p;
          if (e < 2 && e > -2) begin
            ngood = (mgood < 4) ? mgood + 1 : 4;
            nlock = (ngood >= 4) ? 1 : 0;
          end else begin ngood = 0; nlock = 0; end
        end
      end
      ms3 = ms2; ms2 = ms1; ms1 = int'(hsync);
      macc = nacc; mcnt = ncnt; mpix = npix;
      mdint = ndint; mper = nper; mgood = ngood; mlock = nlock; marm = narm;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(pix_en) == mpix, "R10", "pix_en", int'(pix_en), mpix);
      chk(int'(period) == mper, "R6", "period", int'(period), mper);
      chk(int'(lock) == mlock, "R4", "lock", int'(lock), mlock);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_vec++; n_err++;
      $display("FAIL R11 watchdog: actual %0d expected below %0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  int  run_cnt = 0, last_cnt = 0;
  bit  track = 1'b0, saw_drop = 1'b0, saw_relock = 1'b0;

  task automatic drive_lines(input int n, input int len, input bit glitch);
    for (int l = 0; l < n; l++) begin
      for (int c = 0; c < len; c++) begin
        logic act;
        @(negedge clk);
        act = (c < 8) || (glitch && c >= len / 2 && c < len / 2 + 8);
        hsync = act_hi ? act : ~act;
        if (c == 0) begin last_cnt = run_cnt; run_cnt = 0; end
        if (pix_en) run_cnt++;
        if (track) begin
          if (!lock) saw_drop = 1'b1;
          else if (saw_drop) saw_relock = 1'b1;
        end
      end
    end
  endtask

  task automatic pulse_load(input logic [7:0] v);
    @(negedge clk); init_p = v; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  int dv;
  logic [15:0] per0;
  logic        lock0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(period == 16'h0800, "R2", "reset period", int'(period), 2048);
    chk(lock == 1'b0, "R2", "reset lock", int'(lock), 0);
    chk(pix_en == 1'b0, "R1", "reset strobe", int'(pix_en), 0);

    pulse_load(8'd7);
    chk(period == 16'h0700, "R2", "loaded period", int'(period), 16'h0700);

    // lines of 768 cycles, 96 pixels expected (R3)
    drive_lines(60, 768, 1'b0);
    chk(lock == 1'b1, "R4", "lock after settling", int'(lock), 1);
    dv = last_cnt - 96;
    chk(dv <= 2 && dv >= -2, "R3", "pixels per line", last_cnt, 96);

    // extra pulse mid-line gives a bad line (R5)
    drive_lines(1, 768, 1'b1);
    chk(lock == 1'b0, "R5", "lock after bad line", int'(lock), 0);
    drive_lines(10, 768, 1'b0);

    // step in line rate (R11)
    track = 1'b1;
    drive_lines(70, 960, 1'b0);
    track = 1'b0;
    chk(saw_drop, "R11", "lock dropped on step", int'(saw_drop), 1);
    chk(saw_relock, "R11", "lock regained on step", int'(saw_relock), 1);
    chk(lock == 1'b1, "R11", "lock at end of step", int'(lock), 1);
    dv = last_cnt - 96;
    chk(dv <= 2 && dv >= -2, "R11", "pixels per line after step", last_cnt, 96);

    // free run at a different rate (R7)
    per0 = period; lock0 = lock;
    free_run = 1'b1;
    drive_lines(10, 864, 1'b0);
    chk(period == per0, "R7", "period held", int'(period), int'(per0));
    chk(lock == lock0, "R7", "lock held", int'(lock), int'(lock0));
    free_run = 1'b0;

    // falling-edge line start with inverted sync (R8)
    @(negedge clk); hs_rise = 1'b0; act_hi = 1'b0; hsync = 1'b1;
    drive_lines(20, 960, 1'b0);
    chk(lock == 1'b1, "R8", "lock on falling edges", int'(lock), 1);
    dv = last_cnt - 96;
    chk(dv <= 2 && dv >= -2, "R8", "pixels per line falling", last_cnt, 96);

    // loads, including a value under the floor (R9)
    pulse_load(8'd1);
    chk(period == 16'h0200, "R9", "period floor on load", int'(period), 16'h0200);
    chk(lock == 1'b0, "R2", "lock cleared by load", int'(lock), 0);
    pulse_load(8'd10);
    chk(period == 16'h0A00, "R2", "period reload", int'(period), 16'h0A00);
    repeat (20) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule